// File: doc/BRIEF.md
# FIFO Occupancy Flag Unit with Fall-Through Option

This block produces the status flags of a single-clock FIFO of depth `DEPTH`. It does not hold any data. It counts the stored words from the write and read strobes it is given, and it returns three things: whether each strobe was accepted, a strobe that tells the data path to load its output holding register, and five flags. The flags are full or input-ready, empty or output-ready, programmable almost-full, programmable almost-empty and half-full. All flags are registered and change on the clock edge that changes the occupancy.

A mode pin is sampled only while reset is high, and it selects between two modes:

- Standard mode: a read pulls a word out of storage.
- Fall-through mode: the oldest word moves into an output holding register without being asked for, and a read consumes that word. The holding register counts as one extra word of capacity. Every capacity-based threshold therefore moves up by one word, and the output-ready flag only releases on a real read.

The almost-full offset and the almost-empty offset have parameter defaults after reset. Either offset can be rewritten through a small load port.

Top module: `fifo_flag_unit`

## Requirements
- R1: `fwft_sel_i` is captured only while `rst` is high (0 selects standard mode, 1 selects fall-through mode). After reset the flags read as follows. In standard mode: full_ir=1, empty_or=0, paf_n=1, pae_n=0, hf_n=1. In fall-through mode: full_ir=0, empty_or=1, paf_n=1, pae_n=0, hf_n=1. A change of `fwft_sel_i` outside reset has no effect.
- R2: In standard mode, `full_ir_o` goes low on the edge that stores the DEPTH-th word. While it is low, a write is refused (`wr_ok_o`=0).
- R3: In fall-through mode, `full_ir_o` goes high on the edge that brings the total to DEPTH+1 words, holding register included. While it is high, a write is refused.
- R4: In standard mode, `empty_or_o` is low exactly when no words are stored. While it is low, a read is refused (`rd_ok_o`=0).
- R5: In fall-through mode, `empty_or_o` goes low on the same edge at which `load_o` moves a word into the holding register. A word written into an empty unit is loaded on the following edge.
- R6: In fall-through mode, `empty_or_o` stays low after the edge that loads the last stored word. It goes high only on an edge with `rd_en_i` high, when that read leaves nothing to load.
- R7: `paf_n_o` is low when the total is at least C−m, where C is DEPTH (standard) or DEPTH+1 (fall-through) and m is the full offset.
- R8: `pae_n_o` is low when the total is at most n (standard) or n+1 (fall-through), where n is the empty offset.
- R9: `hf_n_o` is low when the total exceeds DEPTH/2 (standard) or DEPTH/2+1 (fall-through). It returns high on the read that brings the total back to that value or below.
- R10: A write while full and a read while empty (or while output-ready is high) are refused and do not change any flag.
- R11: After reset, m=FULL_OFS_DEF and n=EMPTY_OFS_DEF. When `ofs_we_i` is high, the offset register chosen by `ofs_sel_i` (1 selects m, 0 selects n) takes `ofs_data_i`. The flags use the new value from the edge after the loading edge onward.
- R12: When a write and a read are both accepted in the same cycle, the total is unchanged. In standard mode no flag changes either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| fwft_sel_i | input | 1 | Mode select, sampled during reset (1 = fall-through) |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| ofs_we_i | input | 1 | Offset load enable |
| ofs_sel_i | input | 1 | Offset select (1 = almost-full m, 0 = almost-empty n) |
| ofs_data_i | input | CW | Offset value |
| wr_ok_o | output | 1 | Write accepted this cycle |
| rd_ok_o | output | 1 | Read accepted this cycle |
| load_o | output | 1 | Holding register loads a word this cycle |
| full_ir_o | output | 1 | Standard: full, active low. Fall-through: input not ready, active high |
| empty_or_o | output | 1 | Standard: empty, active low. Fall-through: output not ready, active high |
| paf_n_o | output | 1 | Almost-full, active low |
| pae_n_o | output | 1 | Almost-empty, active low |
| hf_n_o | output | 1 | Half-full, active low |

## Verification
Two operations can land in the same cycle: an accepted write and an accepted read. In fall-through mode, a holding-register load can also coincide with a read. The bench drives both strobes together in three situations: at mid occupancy, at full and at empty. At mid occupancy it expects the total and the flags to stay unchanged. At full it expects the write alone to be refused, and at empty the read alone. A scoreboard model that follows the requirements predicts the flags for every cycle.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;

    typedef enum logic {
        OFS_EMPTY = 1'b0,
        OFS_FULL  = 1'b1
    } ofs_sel_e;

    typedef struct packed {
        logic full_ir;
        logic empty_or;
        logic paf_n;
        logic pae_n;
        logic hf_n;
    } flag_vec_t;

    function automatic flag_vec_t flag_reset(input logic fwft);
        flag_vec_t f;
        f.full_ir  = ~fwft;
        f.empty_or = fwft;
        f.paf_n    = 1'b1;
        f.pae_n    = 1'b0;
        f.hf_n     = 1'b1;
        return f;
    endfunction

endpackage

// File: rtl/fifo_flag_cfg.sv
module fifo_flag_cfg
    import fifo_flag_pkg::*;
#(
    parameter int CW            = 5,
    parameter int FULL_OFS_DEF  = 3,
    parameter int EMPTY_OFS_DEF = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fwft_sel_i,
    input  logic          ofs_we_i,
    input  logic          ofs_sel_i,
    input  logic [CW-1:0] ofs_data_i,
    output fifo_mode_e    mode_o,
    output logic [CW-1:0] full_ofs_o,
    output logic [CW-1:0] empty_ofs_o
);
    localparam logic [CW-1:0] M_RST = CW'(FULL_OFS_DEF);
    localparam logic [CW-1:0] N_RST = CW'(EMPTY_OFS_DEF);

    fifo_mode_e    mode_q;
    logic [CW-1:0] m_q;
    logic [CW-1:0] n_q;

    // Mode register: only written while reset is held.
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= fifo_mode_e'(fwft_sel_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            m_q <= M_RST;
            n_q <= N_RST;
        end else if (ofs_we_i) begin
            if (ofs_sel_e'(ofs_sel_i) == OFS_FULL) begin
                m_q <= ofs_data_i;
            end else begin
                n_q <= ofs_data_i;
            end
        end
    end

    assign mode_o      = mode_q;
    assign full_ofs_o  = m_q;
    assign empty_ofs_o = n_q;
endmodule

// File: rtl/fifo_flag_occ.sv
module fifo_flag_occ
    import fifo_flag_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  fifo_mode_e    mode_i,
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    output logic          wr_ok_o,
    output logic          rd_ok_o,
    output logic          load_o,
    output logic [CW-1:0] tot_o,
    output logic [CW-1:0] tot_nx_o,
    output logic          hold_nx_o
);
    localparam logic [CW-1:0] CAP_STD  = CW'(DEPTH);
    localparam logic [CW-1:0] CAP_FWFT = CW'(DEPTH + 1);

    logic [CW-1:0] mem_q, mem_nx;
    logic          hold_q, hold_nx;
    logic [CW-1:0] tot_q, cap;
    logic          fwft, wr_ok, rd_ok, load, mem_dec;

    assign fwft  = (mode_i == MODE_FWFT);
    assign tot_q = mem_q + CW'(hold_q);
    assign cap   = fwft ? CAP_FWFT : CAP_STD;

    always_comb begin
        wr_ok = wr_en_i && !rst && (tot_q != cap);
        if (fwft) begin
            // A true read consumes the holding register.
            rd_ok   = rd_en_i && !rst && hold_q;
            load    = !rst && (mem_q != '0) && (!hold_q || rd_ok);
            mem_dec = load;
            hold_nx = load ? 1'b1 : (rd_ok ? 1'b0 : hold_q);
        end else begin
            rd_ok   = rd_en_i && !rst && (mem_q != '0);
            load    = rd_ok;
            mem_dec = rd_ok;
            hold_nx = 1'b0;
        end
        mem_nx = mem_q + CW'(wr_ok) - CW'(mem_dec);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_q  <= '0;
            hold_q <= 1'b0;
        end else begin
            mem_q  <= mem_nx;
            hold_q <= hold_nx;
        end
    end

    assign wr_ok_o   = wr_ok;
    assign rd_ok_o   = rd_ok;
    assign load_o    = load;
    assign tot_o     = tot_q;
    assign tot_nx_o  = mem_nx + CW'(hold_nx);
    assign hold_nx_o = hold_nx;
endmodule

// File: rtl/fifo_flag_cmp.sv
module fifo_flag_cmp
    import fifo_flag_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input  fifo_mode_e    mode_i,
    input  logic [CW-1:0] tot_i,
    input  logic          hold_i,
    input  logic [CW-1:0] full_ofs_i,
    input  logic [CW-1:0] empty_ofs_i,
    output flag_vec_t     flags_o
);
    localparam logic [CW-1:0] CAP_STD  = CW'(DEPTH);
    localparam logic [CW-1:0] CAP_FWFT = CW'(DEPTH + 1);
    localparam logic [CW-1:0] HALF     = CW'(DEPTH / 2);

    logic          fwft;
    logic [CW-1:0] cap, paf_thr, hf_thr;
    logic [CW:0]   pae_thr;

    assign fwft    = (mode_i == MODE_FWFT);
    assign cap     = fwft ? CAP_FWFT : CAP_STD;
    assign paf_thr = cap - full_ofs_i;
    assign pae_thr = {1'b0, empty_ofs_i} + (CW+1)'(fwft);
    assign hf_thr  = HALF + CW'(fwft);

    always_comb begin
        flags_o.full_ir  = fwft ? (tot_i == cap) : (tot_i != cap);
        flags_o.empty_or = fwft ? !hold_i : (tot_i != '0);
        flags_o.paf_n    = !(tot_i >= paf_thr);
        flags_o.pae_n    = !({1'b0, tot_i} <= pae_thr);
        flags_o.hf_n     = !(tot_i > hf_thr);
    end
endmodule

// File: rtl/fifo_flag_unit.sv
module fifo_flag_unit
    import fifo_flag_pkg::*;
#(
    parameter int DEPTH         = 16,
    parameter int FULL_OFS_DEF  = 3,
    parameter int EMPTY_OFS_DEF = 2,
    parameter int CW            = $clog2(DEPTH + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fwft_sel_i,
    input  logic          wr_en_i,
    input  logic          rd_en_i,
    input  logic          ofs_we_i,
    input  logic          ofs_sel_i,
    input  logic [CW-1:0] ofs_data_i,
    output logic          wr_ok_o,
    output logic          rd_ok_o,
    output logic          load_o,
    output logic          full_ir_o,
    output logic          empty_or_o,
    output logic          paf_n_o,
    output logic          pae_n_o,
    output logic          hf_n_o
);
    fifo_mode_e    mode_q;
    logic [CW-1:0] full_ofs, empty_ofs;
    logic [CW-1:0] tot_q, tot_nx;
    logic          hold_nx;
    flag_vec_t     flags_nx, flags_q;

    fifo_flag_cfg #(
        .CW(CW), .FULL_OFS_DEF(FULL_OFS_DEF), .EMPTY_OFS_DEF(EMPTY_OFS_DEF)
    ) u_cfg (
        .clk(clk), .rst(rst), .fwft_sel_i(fwft_sel_i),
        .ofs_we_i(ofs_we_i), .ofs_sel_i(ofs_sel_i), .ofs_data_i(ofs_data_i),
        .mode_o(mode_q), .full_ofs_o(full_ofs), .empty_ofs_o(empty_ofs)
    );

    fifo_flag_occ #(.DEPTH(DEPTH), .CW(CW)) u_occ (
        .clk(clk), .rst(rst), .mode_i(mode_q),
        .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
        .wr_ok_o(wr_ok_o), .rd_ok_o(rd_ok_o), .load_o(load_o),
        .tot_o(tot_q), .tot_nx_o(tot_nx), .hold_nx_o(hold_nx)
    );

    fifo_flag_cmp #(.DEPTH(DEPTH), .CW(CW)) u_cmp (
        .mode_i(mode_q), .tot_i(tot_nx), .hold_i(hold_nx),
        .full_ofs_i(full_ofs), .empty_ofs_i(empty_ofs),
        .flags_o(flags_nx)
    );

    // Flags are registered from the post-edge occupancy.
    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= flag_reset(fwft_sel_i);
        end else begin
            flags_q <= flags_nx;
        end
    end

    assign full_ir_o  = flags_q.full_ir;
    assign empty_or_o = flags_q.empty_or;
    assign paf_n_o    = flags_q.paf_n;
    assign pae_n_o    = flags_q.pae_n;
    assign hf_n_o     = flags_q.hf_n;
endmodule

// File: rtl/fifo_flag_chk.sv
module fifo_flag_chk
    import fifo_flag_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst,
    input fifo_mode_e    mode_q,
    input logic [CW-1:0] tot_q,
    input logic          wr_en_i,
    input logic          rd_en_i,
    input logic          wr_ok_o,
    input logic          rd_ok_o,
    input logic          load_o,
    input logic          full_ir_o,
    input logic          empty_or_o,
    input logic          hf_n_o
);
    localparam logic [CW-1:0] CAP_STD  = CW'(DEPTH);
    localparam logic [CW-1:0] CAP_FWFT = CW'(DEPTH + 1);
    localparam logic [CW-1:0] HALF     = CW'(DEPTH / 2);

    p_mode_hold_r1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mode_q));

    p_full_blocks_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_STD && !full_ir_o && wr_en_i) |-> !wr_ok_o);

    p_ir_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_FWFT && full_ir_o && wr_en_i) |-> !wr_ok_o);

    p_empty_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_STD && !empty_or_o && rd_en_i) |-> !rd_ok_o);

    p_or_on_load_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_FWFT && load_o) |=> !empty_or_o);

    p_or_release_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_FWFT && !empty_or_o && !rd_en_i) |=> !empty_or_o);

    p_hf_level_r9: assert property (@(posedge clk) disable iff (rst)
        !hf_n_o |-> (tot_q > HALF + CW'(mode_q == MODE_FWFT)));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        tot_q <= ((mode_q == MODE_FWFT) ? CAP_FWFT : CAP_STD));

    p_rw_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (wr_ok_o && rd_ok_o) |=> $stable(tot_q));
endmodule

bind fifo_flag_unit fifo_flag_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst(rst), .mode_q(mode_q), .tot_q(tot_q),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .wr_ok_o(wr_ok_o),
    .rd_ok_o(rd_ok_o), .load_o(load_o), .full_ir_o(full_ir_o),
    .empty_or_o(empty_or_o), .hf_n_o(hf_n_o)
);

// File: tb/fifo_flag_unit_tb.sv
module fifo_flag_unit_tb;
    import fifo_flag_pkg::*;

    localparam int D    = 16;
    localparam int MDEF = 3;
    localparam int NDEF = 2;
    localparam int CW   = $clog2(D + 2);

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst = 1'b1, fwft_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic          ofs_we = 1'b0, ofs_sel = 1'b0;
    logic [CW-1:0] ofs_data = '0;
    logic          wr_ok, rd_ok, load;
    flag_vec_t     act;

    fifo_flag_unit #(.DEPTH(D), .FULL_OFS_DEF(MDEF), .EMPTY_OFS_DEF(NDEF)) u_dut (
        .clk(clk), .rst(rst), .fwft_sel_i(fwft_sel), .wr_en_i(wr_en),
        .rd_en_i(rd_en), .ofs_we_i(ofs_we), .ofs_sel_i(ofs_sel),
        .ofs_data_i(ofs_data), .wr_ok_o(wr_ok), .rd_ok_o(rd_ok),
        .load_o(load), .full_ir_o(act.full_ir), .empty_or_o(act.empty_or),
        .paf_n_o(act.paf_n), .pae_n_o(act.pae_n), .hf_n_o(act.hf_n)
    );

    typedef struct {
        flag_vec_t f;
        string     tag;
    } exp_t;
    exp_t q[$];

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Reference model state, derived from the requirements.
    bit md_fw;
    int md_mem, md_hold, md_m, md_n;

    function automatic flag_vec_t model_flags();
        flag_vec_t f;
        int tot = md_mem + md_hold;
        int cap = md_fw ? D + 1 : D;
        f.full_ir  = md_fw ? (tot == cap) : (tot != cap);
        f.empty_or = md_fw ? (md_hold == 0) : (tot != 0);
        f.paf_n    = !(tot >= cap - md_m);
        f.pae_n    = !(tot <= md_n + int'(md_fw));
        f.hf_n     = !(tot > D / 2 + int'(md_fw));
        return f;
    endfunction

    task automatic check_bits(string tag, string what, logic [1:0] a, logic [1:0] e);
        n_chk++;
        if (a !== e) begin
            n_fail++;
            $display("FAIL %s %s act=%b exp=%b", tag, what, a, e);
        end
    endtask

    task automatic cyc(bit wr, bit rd, string tag, bit ow = 0, bit osel = 0, int odat = 0);
        exp_t e;
        int   tot, cap, wok, rok, ld;
        @(negedge clk);
        wr_en = wr; rd_en = rd; ofs_we = ow; ofs_sel = osel; ofs_data = CW'(odat);
        tot = md_mem + md_hold;
        cap = md_fw ? D + 1 : D;
        wok = (wr && tot != cap) ? 1 : 0;
        if (md_fw) begin
            rok = (rd && md_hold == 1) ? 1 : 0;
            ld  = (md_mem > 0 && (md_hold == 0 || rok == 1)) ? 1 : 0;
            md_mem  = md_mem + wok - ld;
            md_hold = ld ? 1 : (rok ? 0 : md_hold);
        end else begin
            rok = (rd && tot != 0) ? 1 : 0;
            md_mem = md_mem + wok - rok;
        end
        e.f = model_flags();
        e.tag = tag;
        q.push_back(e);
        if (ow) begin
            if (osel) md_m = odat;
            else      md_n = odat;
        end
        #1;
        check_bits(tag, "wr_ok/rd_ok", {wr_ok, rd_ok}, {wok[0], rok[0]});
    endtask

    task automatic do_reset(bit fw);
        exp_t e;
        md_fw = fw; md_mem = 0; md_hold = 0; md_m = MDEF; md_n = NDEF;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            rst = 1'b1; fwft_sel = fw; wr_en = 0; rd_en = 0; ofs_we = 0;
            e.f = model_flags();
            e.tag = "R1 reset";
            q.push_back(e);
        end
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Monitor: compares the flags after each edge against the scoreboard.
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (!done && q.size() > 0) begin
            e = q.pop_front();
            n_chk++;
            if (act !== e.f) begin
                n_fail++;
                $display("FAIL %s flags act=%b exp=%b", e.tag, act, e.f);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // Standard mode
        do_reset(0);
        for (int i = 0; i < D; i++) cyc(1, 0, "R2 R7 R9 fill");
        cyc(1, 0, "R10 write while full");
        cyc(1, 0, "R10 write while full");
        cyc(1, 1, "R10 write refused, read taken");
        for (int i = 0; i < D - 1; i++) cyc(0, 1, "R4 R8 R9 drain");
        cyc(0, 1, "R10 read while empty");
        cyc(1, 1, "R10 read refused at empty");
        for (int i = 0; i < 4; i++) cyc(1, 0, "R8 refill");
        for (int i = 0; i < 3; i++) cyc(1, 1, "R12 simultaneous");
        cyc(0, 0, "R11 load m", 1, 1, 8);
        cyc(0, 0, "R11 load n", 1, 0, 6);
        cyc(0, 0, "R11 new offsets");
        for (int i = 0; i < 5; i++) cyc(1, 0, "R7 R11 new m");
        fwft_sel = 1'b1;
        cyc(0, 0, "R1 select ignored outside reset");
        cyc(1, 0, "R1 still standard");

        // Fall-through mode
        do_reset(1);
        cyc(0, 0, "R11 offsets back to defaults");
        cyc(1, 0, "R5 first write");
        cyc(0, 0, "R5 fall through");
        cyc(0, 0, "R6 holds with no read");
        cyc(0, 0, "R6 holds with no read");
        cyc(0, 1, "R6 true read");
        cyc(0, 1, "R10 read while not ready");
        for (int i = 0; i < D + 1; i++) cyc(1, 0, "R3 R7 R8 R9 fill");
        cyc(1, 0, "R10 write while input not ready");
        cyc(1, 1, "R3 write refused, read taken");
        for (int i = 0; i < 3; i++) cyc(1, 0, "R3 refill");
        for (int i = 0; i < D + 1; i++) cyc(0, 1, "R6 R8 R9 drain");
        cyc(0, 1, "R10 read while empty");
        cyc(0, 0, "R6 idle");
        for (int i = 0; i < 5; i++) cyc(1, 0, "R12 prefill");
        for (int i = 0; i < 3; i++) cyc(1, 1, "R12 simultaneous");
        fwft_sel = 1'b0;
        cyc(0, 0, "R1 select ignored outside reset");
        cyc(0, 1, "R1 still fall-through");
        repeat (2) @(negedge clk);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule